// File: doc/BRIEF.md
# Reaping Source Ring Producer

This block runs the producer end of a circular descriptor ring whose size need not be a power of two. It holds three word pointers: the head where the next descriptor is posted, a cached copy of the consumer's tail, and a reap pointer. The reap pointer sits between head and tail. Entries the consumer has finished with are walked and freed through the reap pointer before their slots may be posted again. Every pointer moves one entry at a time, wrapping modulo the ring size.

Software-side logic drives one request per cycle on a valid/ready port. A session opens by sampling the consumer tail. Inside a session the requester can take the next free slot, peek at it, count the free slots, reap the next completed slot, post into a slot already reaped, or count the completed slots. Slot and count answers come back in the same cycle the request is accepted. A normal session close publishes the head to the consumer. A reap-session close releases the session and publishes nothing.

The ready rule is the only back-pressure. An open request waits while a session is open, and every other request waits while no session is open. A request held with ready low has no effect and may stay asserted.

Top module: `reap_ring_producer`

## Requirements
- R1: After reset, head, reap pointer and cached tail are 0, no session is open and `pub_valid` is low.
- R2: `req_op` codes are OPEN=0, CLOSE_POST=1, CLOSE_REAP=2, GET=3, PEEK=4, FREE=5, REAP=6, GET_REAPED=7, DONE=8. `req_ready` is high for OPEN only while no session is open, and for every other code only while one is open. `rsp_valid` equals `req_valid && req_ready`, and a request that is not accepted changes no state.
- R3: GET hits when (head + ENTRY_WORDS) mod RING_WORDS differs from the cached tail. On a hit, `rsp_slot` is the old head, and head and reap pointer both take the advanced value. On a miss, nothing moves.
- R4: PEEK gives the same hit and slot as GET would, and moves no pointer.
- R5: FREE returns (tail − head)/ENTRY_WORDS − 1 when tail > head, and otherwise (RING_WORDS − head + tail)/ENTRY_WORDS − 1. When `req_sync` is high, `cons_tail` is used as the tail and is stored as the cached tail.
- R6: REAP computes n = (reap + ENTRY_WORDS) mod RING_WORDS. If n differs from the cached tail, it hits with `rsp_slot` = n and the reap pointer becomes n. Otherwise it misses and nothing moves.
- R7: GET_REAPED hits only while head differs from the reap pointer. On a hit, `rsp_slot` is the old head and head advances one entry.
- R8: DONE returns 0 when n (as in R6) equals the cached tail. Otherwise it returns the forward distance from n to the tail in entries, wrapping where needed.
- R9: An accepted CLOSE_POST makes `pub_valid` high for exactly the next cycle, with `pub_head` equal to the head. CLOSE_REAP closes the session with `pub_valid` left low.
- R10: An accepted OPEN loads `cons_tail` into the cached tail. Later changes on `cons_tail` are ignored until the next OPEN or synced FREE.
- R11: A pointer advancing from RING_WORDS − ENTRY_WORDS wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 4 | Request code (see R2) |
| req_sync | input | 1 | FREE only: use and cache `cons_tail` |
| cons_tail | input | PW | Consumer tail, word index |
| rsp_valid | output | 1 | Request accepted this cycle |
| rsp_hit | output | 1 | Slot-returning request succeeded |
| rsp_slot | output | PW | Word index of returned slot |
| rsp_count | output | CW | FREE / DONE result in entries |
| pub_valid | output | 1 | Head published to consumer |
| pub_head | output | PW | Published head, word index |

## Verification
The bench uses a 12-word ring with 3-word entries. It first runs directed sequences. One fills the ring from reset until GET misses, which separates the one-empty-slot rule from an off-by-one. One reopens with a tail that forces head to wrap. One changes `cons_tail` without an OPEN, which shows whether the cached tail was captured or is read live. After that, a long pseudo-random stream mixes all nine codes with arbitrary entry-aligned tails and sync flags, including requests made while ready is low. An arithmetic model predicts every hit, slot, count and publish, so equal-pointer, wrapped and unwrapped distances are all met many times.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [3:0] {
    OP_OPEN        = 4'd0,
    OP_CLOSE_POST  = 4'd1,
    OP_CLOSE_REAP  = 4'd2,
    OP_GET         = 4'd3,
    OP_PEEK        = 4'd4,
    OP_FREE        = 4'd5,
    OP_REAP        = 4'd6,
    OP_GET_REAPED  = 4'd7,
    OP_DONE        = 4'd8
  } srp_op_e;
endpackage

// File: rtl/srp_wrap_add.sv
// Advance a word pointer by one entry, modulo the ring size.
module srp_wrap_add #(
  parameter int RING_WORDS  = 12,
  parameter int ENTRY_WORDS = 3,
  parameter int PW          = 4
) (
  input  logic [PW-1:0] ptr,
  output logic [PW-1:0] nxt
);
  localparam logic [PW:0] RING_L  = (PW+1)'(RING_WORDS);
  localparam logic [PW:0] ENTRY_L = (PW+1)'(ENTRY_WORDS);
  localparam bit RING_POW2 = (RING_WORDS & (RING_WORDS - 1)) == 0;

  logic [PW:0] sum;
  assign sum = {1'b0, ptr} + ENTRY_L;

  generate
    if (RING_POW2) begin : g_mask
      assign nxt = sum[PW-1:0];
    end else begin : g_sub
      logic [PW:0] wrapped;
      assign wrapped = (sum >= RING_L) ? (sum - RING_L) : sum;
      assign nxt = wrapped[PW-1:0];
    end
  endgenerate
endmodule

// File: rtl/srp_span_count.sv
// Forward distance from one pointer to another, in entries; equal pointers span the full ring.
module srp_span_count #(
  parameter int RING_WORDS  = 12,
  parameter int ENTRY_WORDS = 3,
  parameter int PW          = 4,
  parameter int CW          = 3
) (
  input  logic [PW-1:0] from_ptr,
  input  logic [PW-1:0] to_ptr,
  output logic [CW-1:0] entries
);
  localparam logic [PW:0] RING_L  = (PW+1)'(RING_WORDS);
  localparam logic [PW:0] ENTRY_L = (PW+1)'(ENTRY_WORDS);
  localparam bit ENTRY_POW2 = (ENTRY_WORDS & (ENTRY_WORDS - 1)) == 0;
  localparam int ESH = $clog2(ENTRY_WORDS);

  logic [PW:0] words;
  assign words = (to_ptr > from_ptr) ? ({1'b0, to_ptr} - {1'b0, from_ptr})
                                     : (RING_L - {1'b0, from_ptr} + {1'b0, to_ptr});

  generate
    if (ENTRY_POW2) begin : g_shift
      logic [PW:0] q;
      assign q = words >> ESH;
      assign entries = CW'(q);
    end else begin : g_div
      logic [PW:0] q;
      assign q = words / ENTRY_L;
      assign entries = CW'(q);
    end
  endgenerate
endmodule

// File: rtl/srp_session.sv
// Session open flag and head publication register.
module srp_session #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_req,
  input  logic          close_post,
  input  logic          close_reap,
  input  logic [PW-1:0] head,
  output logic          open_q,
  output logic          pub_valid,
  output logic [PW-1:0] pub_head
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      pub_valid <= 1'b0;
      pub_head  <= '0;
    end else begin
      pub_valid <= close_post;
      if (close_post) pub_head <= head;
      if (open_req) open_q <= 1'b1;
      else if (close_post || close_reap) open_q <= 1'b0;
    end
  end

  // R2
  open_only_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_req |-> !open_q);
  // R2
  close_only_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_post || close_reap) |-> open_q);
endmodule

// File: rtl/reap_ring_producer.sv
module reap_ring_producer
  import srp_pkg::*;
#(
  parameter int RING_WORDS  = 12,
  parameter int ENTRY_WORDS = 3,
  localparam int PW = $clog2(RING_WORDS),
  localparam int CW = $clog2(RING_WORDS / ENTRY_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_op,
  input  logic          req_sync,
  input  logic [PW-1:0] cons_tail,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [PW-1:0] rsp_slot,
  output logic [CW-1:0] rsp_count,
  output logic          pub_valid,
  output logic [PW-1:0] pub_head
);
  localparam int NUM_ENTRIES = RING_WORDS / ENTRY_WORDS;
  localparam logic [PW:0] RING_L = (PW+1)'(RING_WORDS);

  srp_op_e op;
  assign op = srp_op_e'(req_op);

  logic [PW-1:0] head_q, reap_q, tail_q;
  logic [PW-1:0] head_nxt, reap_nxt, tail_use;
  logic [CW-1:0] free_span, done_span;
  logic          open_q, accept;
  logic          get_ok, reap_ok, reaped_ok;

  assign req_ready = (op == OP_OPEN) ? !open_q : open_q;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = accept;

  assign tail_use = (op == OP_FREE && req_sync) ? cons_tail : tail_q;

  srp_wrap_add #(.RING_WORDS(RING_WORDS), .ENTRY_WORDS(ENTRY_WORDS), .PW(PW))
    u_head_adv (.ptr(head_q), .nxt(head_nxt));
  srp_wrap_add #(.RING_WORDS(RING_WORDS), .ENTRY_WORDS(ENTRY_WORDS), .PW(PW))
    u_reap_adv (.ptr(reap_q), .nxt(reap_nxt));

  srp_span_count #(.RING_WORDS(RING_WORDS), .ENTRY_WORDS(ENTRY_WORDS), .PW(PW), .CW(CW))
    u_free_span (.from_ptr(head_q), .to_ptr(tail_use), .entries(free_span));
  srp_span_count #(.RING_WORDS(RING_WORDS), .ENTRY_WORDS(ENTRY_WORDS), .PW(PW), .CW(CW))
    u_done_span (.from_ptr(reap_nxt), .to_ptr(tail_q), .entries(done_span));

  assign get_ok    = head_nxt != tail_use;
  assign reap_ok   = reap_nxt != tail_q;
  assign reaped_ok = head_q != reap_q;

  always_comb begin
    rsp_hit   = 1'b0;
    rsp_slot  = '0;
    rsp_count = '0;
    if (accept) begin
      unique case (op)
        OP_GET, OP_PEEK: begin
          rsp_hit  = get_ok;
          rsp_slot = head_q;
        end
        OP_REAP: begin
          rsp_hit  = reap_ok;
          rsp_slot = reap_nxt;
        end
        OP_GET_REAPED: begin
          rsp_hit  = reaped_ok;
          rsp_slot = head_q;
        end
        OP_FREE: rsp_count = free_span - CW'(1);
        OP_DONE: rsp_count = reap_ok ? done_span : '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      reap_q <= '0;
      tail_q <= '0;
    end else if (accept) begin
      unique case (op)
        OP_OPEN: tail_q <= cons_tail;
        OP_FREE: if (req_sync) tail_q <= cons_tail;
        OP_GET: if (get_ok) begin
          head_q <= head_nxt;
          reap_q <= head_nxt;
        end
        OP_REAP: if (reap_ok) reap_q <= reap_nxt;
        OP_GET_REAPED: if (reaped_ok) head_q <= head_nxt;
        default: ;
      endcase
    end
  end

  srp_session #(.PW(PW)) u_session (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_req   (accept && op == OP_OPEN),
    .close_post (accept && op == OP_CLOSE_POST),
    .close_reap (accept && op == OP_CLOSE_REAP),
    .head       (head_q),
    .open_q     (open_q),
    .pub_valid  (pub_valid),
    .pub_head   (pub_head)
  );

  // R11
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, head_q} < RING_L) && ({1'b0, reap_q} < RING_L) && ({1'b0, tail_q} < RING_L));
  // R3
  get_joins_reap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_GET && rsp_hit) |=> (reap_q == head_q) && (head_q != $past(head_q)));
  // R4
  peek_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PEEK) |=> $stable(head_q) && $stable(reap_q));
  // R5
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_FREE) |-> (int'(rsp_count) <= NUM_ENTRIES - 1));
  // R9
  publish_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CLOSE_POST) |=> pub_valid && (pub_head == $past(head_q)));
  // R9
  reap_close_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CLOSE_REAP) |=> !pub_valid);
  // R2
  idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(head_q) && $stable(reap_q) && $stable(tail_q));
endmodule

// File: tb/tb_reap_ring_producer.sv
module tb_reap_ring_producer;
  localparam int R  = 12;
  localparam int E  = 3;
  localparam int PW = $clog2(R);
  localparam int CW = $clog2(R / E + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [3:0]    req_op;
  logic          req_sync;
  logic [PW-1:0] cons_tail;
  logic          rsp_valid, rsp_hit;
  logic [PW-1:0] rsp_slot;
  logic [CW-1:0] rsp_count;
  logic          pub_valid;
  logic [PW-1:0] pub_head;

  always #2 clk = ~clk;

  reap_ring_producer #(.RING_WORDS(R), .ENTRY_WORDS(E)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sync(req_sync), .cons_tail(cons_tail),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slot(rsp_slot),
    .rsp_count(rsp_count), .pub_valid(pub_valid), .pub_head(pub_head)
  );

  int n_chk = 0;
  int n_fail = 0;
  int m_head = 0, m_reap = 0, m_tail = 0;
  bit m_open = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int adv(input int p);
    return (p + E) % R;
  endfunction

  function automatic int span(input int f, input int t);
    return (t > f) ? (t - f) / E : (R - f + t) / E;
  endfunction

  // Issue one request; check the response mid-cycle, then the publish output after the edge.
  task automatic do_op(input int op, input bit sync, input int ctail, input string tag);
    bit acc;
    int tl;
    int nh, nr, nt;
    bit hit;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 4'(op);
    req_sync  = sync;
    cons_tail = PW'(ctail);
    #1;
    acc = (op == 0) ? !m_open : m_open;
    chk("R2", int'(req_ready), int'(acc));
    chk("R2", int'(rsp_valid), int'(acc));
    nh = m_head; nr = m_reap; nt = m_tail;
    if (acc) begin
      tl = (op == 5 && sync) ? ctail : m_tail;
      case (op)
        3, 4: begin
          hit = adv(m_head) != tl;
          chk(tag == "" ? (op == 3 ? "R3" : "R4") : tag, int'(rsp_hit), int'(hit));
          if (hit) chk(op == 3 ? "R3" : "R4", int'(rsp_slot), m_head);
          if (op == 3 && hit) begin nh = adv(m_head); nr = nh; end
        end
        5: begin
          chk(tag == "" ? "R5" : tag, int'(rsp_count), span(m_head, tl) - 1);
          if (sync) nt = ctail;
        end
        6: begin
          hit = adv(m_reap) != m_tail;
          chk("R6", int'(rsp_hit), int'(hit));
          if (hit) begin chk("R6", int'(rsp_slot), adv(m_reap)); nr = adv(m_reap); end
        end
        7: begin
          hit = m_head != m_reap;
          chk("R7", int'(rsp_hit), int'(hit));
          if (hit) begin chk("R7", int'(rsp_slot), m_head); nh = adv(m_head); end
        end
        8: chk("R8", int'(rsp_count), (adv(m_reap) == m_tail) ? 0 : span(adv(m_reap), m_tail));
        0: nt = ctail;
        default: ;
      endcase
      if ((op == 3 || op == 7) && hit && m_head == R - E) chk("R11", nh, 0);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk("R9", int'(pub_valid), int'(acc && op == 1));
    if (acc && op == 1) chk("R9", int'(pub_head), m_head);
    if (acc) begin
      if (op == 0) m_open = 1'b1;
      if (op == 1 || op == 2) m_open = 1'b0;
    end
    m_head = nh; m_reap = nr; m_tail = nt;
  endtask

  initial begin : watchdog
    #700000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_op = '0; req_sync = 1'b0; cons_tail = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    chk("R1", int'(pub_valid), 0);
    req_op = 4'd0; #0.5;
    chk("R1", int'(req_ready), 1);
    req_op = 4'd3; #0.5;
    chk("R1", int'(req_ready), 0);

    do_op(3, 0, 0, "");           // rejected: no session (R2)
    do_op(0, 0, 0, "");           // open, tail 0
    do_op(5, 0, 0, "R1");         // free = 3 from zeroed pointers
    do_op(8, 0, 0, "");           // done = 3
    do_op(4, 0, 0, "");           // peek slot 0
    do_op(3, 0, 0, ""); do_op(3, 0, 0, ""); do_op(3, 0, 0, "");
    do_op(3, 0, 0, "");           // full: miss
    do_op(5, 0, 0, "");           // free = 0
    do_op(0, 0, 0, "");           // rejected while open
    do_op(1, 0, 0, "");           // publish head 9
    do_op(0, 0, 9, "");           // open with tail 9
    do_op(3, 0, 0, "");           // slot 9, head wraps to 0 (R11)
    do_op(5, 0, 3, "R10");        // cons_tail ignored without sync
    do_op(5, 1, 6, "R5");         // synced tail 6
    do_op(6, 0, 0, ""); do_op(6, 0, 0, ""); do_op(8, 0, 0, "");
    do_op(7, 0, 0, ""); do_op(7, 0, 0, ""); do_op(7, 0, 0, "");
    do_op(2, 0, 0, "");           // reap close: no publish

    for (int i = 0; i < 6000; i++) begin
      int op, ct;
      bit sy;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = int'(lfsr[3:0]) % 9;
      sy = lfsr[7];
      ct = (int'(lfsr[11:8]) % (R / E)) * E;
      do_op(op, sy, ct, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule